// File: doc/BRIEF.md
# Nested priority interrupt controller

This block collects a bank of interrupt inputs and presents a single active-low request line to a processor. Each input carries its own enable bit, a trigger mode (rising-edge or level), a priority from 0 (lowest) to the maximum, and a programmable vector word. A small register bus configures the sources. The same bus carries the two handshake operations of an interrupt: a read of the vector register, which acknowledges the winner, and a write to the end-of-interrupt register, which closes it.

A vector read makes the best eligible source the one in service. It pushes that source's priority and number onto a hardware nesting stack, so only a strictly higher priority can raise the request again. An end-of-interrupt write pops the stack. The request is then judged against the level that has been restored. Nested preemption therefore needs no software bookkeeping of the priority threshold.

Register map (word addresses, 7-bit address): 0 enable mask (bit i = source i); 1 trigger mask (1 = rising-edge, 0 = level); 2 vector / acknowledge (read); 3 end-of-interrupt (write, data ignored); 4 default vector; 5 pending flags (read); 6 current source (read: number in the low bits, bit 31 set when nothing is in service); 64 + 2·i priority of source i (low 3 bits); 65 + 2·i vector word of source i.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset every source is disabled and level-triggered, all priorities, vector words and the default vector are 0, the stack is empty, and the request output is high (inactive).
- R2: In rising-edge mode a source sets its pending flag (bit i of register 5) once per low-to-high transition; holding the input high for many cycles sets it only once.
- R3: In level mode the pending flag follows the input; acknowledging does not clear it, and it drops when the input drops.
- R4: Only sources that are both pending and enabled compete. The highest priority wins, and between equal priorities the lowest source number wins.
- R5: With the stack empty, the request output is low whenever any pending, enabled source exists.
- R6: A vector read with an eligible winner returns that source's vector word, pushes its priority and number, and makes register 6 report that number; the request then goes high unless a strictly higher source is pending.
- R7: Acknowledging a rising-edge source clears its pending flag.
- R8: While the stack is not empty, the request output is low only when a pending, enabled source has a priority strictly above the level on top of the stack.
- R9: An end-of-interrupt write pops one level. The request is re-asserted when a pending source is above the restored level, even if its priority is at or below the level just finished.
- R10: A vector read with no source above the current level returns the default vector (register 4) and leaves the stack unchanged.
- R11: An end-of-interrupt write with an empty stack has no effect.
- R12: The stack holds eight nested levels, one per priority value, and unwinds them in reverse order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_src_i | input | 32 | Interrupt source inputs |
| bus_addr_i | input | 7 | Register word address |
| bus_wr_i | input | 1 | Write strobe, takes effect at the clock edge |
| bus_wdata_i | input | 32 | Write data |
| bus_rd_i | input | 1 | Read strobe; side effects of a read happen at the clock edge |
| bus_rdata_o | output | 32 | Read data, valid in the same cycle as the read strobe |
| irq_n_o | output | 1 | Interrupt request to the processor, active low |

## Verification
The bench raises two equal-priority edge sources together and expects the lower-numbered one to win. A tie-break that favoured the higher index would return the wrong vector. It holds an edge source high across an acknowledge, because a detector working on the level instead of the transition would re-pend it and keep the request low. It checks that a default-vector read pushes nothing and that an end-of-interrupt write on an empty stack leaves no stray level behind. Either fault would leave a phantom level on the stack that masks later requests. It also drives the return path where a source at the finished level must re-raise the request against a lower restored level, and it fills all eight stack slots and unwinds them.

// File: rtl/nic_pkg.sv
package nic_pkg;
    localparam int NIC_NUM_SRC     = 32;
    localparam int NIC_PRIO_W      = 3;
    localparam int NIC_STACK_DEPTH = 8;
    localparam int NIC_DATA_W      = 32;

    // low-region register word addresses
    localparam int REG_ENABLE  = 0;
    localparam int REG_TRIGGER = 1;
    localparam int REG_VECTOR  = 2;
    localparam int REG_EOI     = 3;
    localparam int REG_DEFAULT = 4;
    localparam int REG_PENDING = 5;
    localparam int REG_CURRENT = 6;
endpackage

// File: rtl/nic_src_bank.sv
module nic_src_bank #(
    parameter int N_SRC = nic_pkg::NIC_NUM_SRC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_i,
    input  logic [N_SRC-1:0] mode_edge_i,
    input  logic [N_SRC-1:0] ack_clr_i,
    output logic [N_SRC-1:0] pend_o
);
    typedef struct packed {
        logic [N_SRC-1:0] smp;
        logic [N_SRC-1:0] prev;
        logic [N_SRC-1:0] epend;
    } bank_t;

    bank_t st_d, st_q;
    logic [N_SRC-1:0] rise;

    always_comb begin
        st_d       = st_q;
        rise       = st_q.smp & ~st_q.prev;
        st_d.smp   = src_i;
        st_d.prev  = st_q.smp;
        st_d.epend = ((st_q.epend & ~ack_clr_i) | rise) & mode_edge_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        assign pend_o[g] = mode_edge_i[g] ? st_q.epend[g] : st_q.smp[g];

        // R2: a seen transition in edge mode lands in the pending flag
        a_r2_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_edge_i[g] && st_q.smp[g] && !st_q.prev[g]) |=> st_q.epend[g]);

        // R7: acknowledge without a fresh transition clears the flag
        a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_clr_i[g] && !(st_q.smp[g] && !st_q.prev[g])) |=> !st_q.epend[g]);
    end
endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter #(
    parameter int N_SRC  = nic_pkg::NIC_NUM_SRC,
    parameter int PRIO_W = nic_pkg::NIC_PRIO_W,
    localparam int ID_W  = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0]             elig_i,
    input  logic [N_SRC-1:0][PRIO_W-1:0] prio_i,
    output logic                         valid_o,
    output logic [ID_W-1:0]              id_o,
    output logic [PRIO_W-1:0]            prio_o
);
    // ascending scan with strict compare keeps the lowest index on ties
    always_comb begin
        valid_o = 1'b0;
        id_o    = '0;
        prio_o  = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (elig_i[i] && (!valid_o || prio_i[i] > prio_o)) begin
                valid_o = 1'b1;
                id_o    = ID_W'(i);
                prio_o  = prio_i[i];
            end
        end
    end
endmodule

// File: rtl/nic_nest_stack.sv
module nic_nest_stack #(
    parameter int DEPTH  = nic_pkg::NIC_STACK_DEPTH,
    parameter int PRIO_W = nic_pkg::NIC_PRIO_W,
    parameter int ID_W   = 5,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int ENT_W = PRIO_W + ID_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [PRIO_W-1:0] push_prio_i,
    input  logic [ID_W-1:0]   push_id_i,
    input  logic              pop_i,
    output logic              empty_o,
    output logic [PRIO_W-1:0] top_prio_o,
    output logic [ID_W-1:0]   top_id_o,
    output logic [CNT_W-1:0]  count_o
);
    typedef struct packed {
        logic [DEPTH-1:0][ENT_W-1:0] ent;
        logic [CNT_W-1:0]            cnt;
    } stk_t;

    stk_t st_d, st_q;
    logic [ENT_W-1:0] top_ent;

    always_comb begin
        st_d = st_q;
        if (pop_i && st_q.cnt != '0)
            st_d.cnt = st_q.cnt - 1'b1;
        if (push_i && st_d.cnt < CNT_W'(DEPTH)) begin
            st_d.ent[st_d.cnt] = {push_prio_i, push_id_i};
            st_d.cnt           = st_d.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign top_ent    = (st_q.cnt == '0) ? '0 : st_q.ent[st_q.cnt - 1'b1];
    assign empty_o    = (st_q.cnt == '0);
    assign top_prio_o = top_ent[ENT_W-1:ID_W];
    assign top_id_o   = top_ent[ID_W-1:0];
    assign count_o    = st_q.cnt;

    // R12: occupancy never exceeds the stack depth
    a_r12_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH));

    // R11: a pop on an empty stack leaves it empty
    a_r11_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && st_q.cnt == '0) |=> st_q.cnt == '0);
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl #(
    parameter int N_SRC        = nic_pkg::NIC_NUM_SRC,
    parameter int PRIO_W       = nic_pkg::NIC_PRIO_W,
    parameter int STACK_DEPTH  = nic_pkg::NIC_STACK_DEPTH,
    parameter int DATA_W       = nic_pkg::NIC_DATA_W,
    localparam int ID_W        = $clog2(N_SRC),
    localparam int ADDR_W      = ID_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  irq_src_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_wr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    input  logic              bus_rd_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_n_o
);
    import nic_pkg::*;

    localparam int CNT_W = $clog2(STACK_DEPTH + 1);

    typedef struct packed {
        logic [N_SRC-1:0]             en;
        logic [N_SRC-1:0]             mode_edge;
        logic [DATA_W-1:0]            dflt;
        logic [N_SRC-1:0][PRIO_W-1:0] prio;
        logic [N_SRC-1:0][DATA_W-1:0] vec;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic [N_SRC-1:0]  pend, elig, ack_clr;
    logic              win_valid;
    logic [ID_W-1:0]   win_id;
    logic [PRIO_W-1:0] win_prio;
    logic              stk_empty;
    logic [PRIO_W-1:0] stk_prio;
    logic [ID_W-1:0]   stk_id;
    logic [CNT_W-1:0]  stk_count;
    logic              src_region;
    logic [ID_W-1:0]   reg_idx;
    logic              above, vec_rd, take, eoi;

    assign src_region = bus_addr_i[ADDR_W-1];
    assign reg_idx    = bus_addr_i[ID_W:1];
    assign elig       = pend & cfg_q.en;
    assign above      = win_valid && (stk_empty || win_prio > stk_prio);
    assign vec_rd     = bus_rd_i && (bus_addr_i == ADDR_W'(REG_VECTOR));
    assign take       = vec_rd && above;
    assign eoi        = bus_wr_i && (bus_addr_i == ADDR_W'(REG_EOI));
    assign irq_n_o    = !above;

    always_comb begin
        ack_clr = '0;
        if (take) ack_clr[win_id] = cfg_q.mode_edge[win_id];
    end

    nic_src_bank #(.N_SRC(N_SRC)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_i      (irq_src_i),
        .mode_edge_i(cfg_q.mode_edge),
        .ack_clr_i  (ack_clr),
        .pend_o     (pend)
    );

    nic_arbiter #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_arb (
        .elig_i (elig),
        .prio_i (cfg_q.prio),
        .valid_o(win_valid),
        .id_o   (win_id),
        .prio_o (win_prio)
    );

    nic_nest_stack #(.DEPTH(STACK_DEPTH), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (take),
        .push_prio_i(win_prio),
        .push_id_i  (win_id),
        .pop_i      (eoi),
        .empty_o    (stk_empty),
        .top_prio_o (stk_prio),
        .top_id_o   (stk_id),
        .count_o    (stk_count)
    );

    // configuration writes
    always_comb begin
        cfg_d = cfg_q;
        if (bus_wr_i) begin
            if (src_region) begin
                if (bus_addr_i[0]) cfg_d.vec[reg_idx]  = bus_wdata_i;
                else               cfg_d.prio[reg_idx] = bus_wdata_i[PRIO_W-1:0];
            end else begin
                case (bus_addr_i)
                    ADDR_W'(REG_ENABLE):  cfg_d.en        = bus_wdata_i[N_SRC-1:0];
                    ADDR_W'(REG_TRIGGER): cfg_d.mode_edge = bus_wdata_i[N_SRC-1:0];
                    ADDR_W'(REG_DEFAULT): cfg_d.dflt      = bus_wdata_i;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    // read data, valid in the strobe cycle
    always_comb begin
        bus_rdata_o = '0;
        if (src_region) begin
            if (bus_addr_i[0]) bus_rdata_o = cfg_q.vec[reg_idx];
            else               bus_rdata_o = DATA_W'(cfg_q.prio[reg_idx]);
        end else begin
            case (bus_addr_i)
                ADDR_W'(REG_ENABLE):  bus_rdata_o = DATA_W'(cfg_q.en);
                ADDR_W'(REG_TRIGGER): bus_rdata_o = DATA_W'(cfg_q.mode_edge);
                ADDR_W'(REG_VECTOR):  bus_rdata_o = above ? cfg_q.vec[win_id] : cfg_q.dflt;
                ADDR_W'(REG_DEFAULT): bus_rdata_o = cfg_q.dflt;
                ADDR_W'(REG_PENDING): bus_rdata_o = DATA_W'(pend);
                ADDR_W'(REG_CURRENT): begin
                    bus_rdata_o              = DATA_W'(stk_id);
                    bus_rdata_o[DATA_W-1]    = stk_empty;
                end
                default: ;
            endcase
        end
    end

    // R4: the winner is always a pending, enabled source
    a_r4_winner_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> elig[win_id]);

    // R6: an acknowledge taken while the request is low pushes one level
    a_r6_ack_pushes: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_rd && !irq_n_o && !eoi) |=> stk_count == $past(stk_count) + 1'b1);

    // R10: a vector read while the request is high leaves the stack alone
    a_r10_default_no_push: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_rd && irq_n_o && !eoi) |=> stk_count == $past(stk_count));

    // R8: nothing can preempt a level at the top priority
    a_r8_quiet_at_top: assert property (@(posedge clk) disable iff (!rst_n)
        (!stk_empty && stk_prio == '1) |-> irq_n_o);
endmodule

// File: tb/nest_irq_ctrl_tb.sv
module nest_irq_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N_SRC      = 32;
    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 7;
    localparam logic [31:0] VBASE = 32'hC0DE_0000;
    localparam logic [31:0] DFLT  = 32'hDEAD_0000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N_SRC-1:0]  irq_src = '0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic              bus_rd = 1'b0;
    logic [DATA_W-1:0] bus_rdata;
    logic              irq_n;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } exp_t;
    exp_t sb_q[$];
    event rd_ev;

    nest_irq_ctrl dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_src_i  (irq_src),
        .bus_addr_i (bus_addr),
        .bus_wr_i   (bus_wr),
        .bus_wdata_i(bus_wdata),
        .bus_rd_i   (bus_rd),
        .bus_rdata_o(bus_rdata),
        .irq_n_o    (irq_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: run hung, actual=expired expected=complete");
        finish_run();
    end

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: compares every read result against the scoreboard
    initial begin
        forever begin
            exp_t item;
            @(rd_ev);
            item = sb_q.pop_front();
            check(bus_rdata, item.exp, item.tag);
        end
    end

    task automatic bus_read(input int addr, input logic [31:0] exp, input string tag);
        exp_t item;
        @(negedge clk);
        bus_addr = ADDR_W'(addr);
        bus_rd   = 1'b1;
        item.exp = exp;
        item.tag = tag;
        sb_q.push_back(item);
        #1 -> rd_ev;
        @(posedge clk);
        #1 bus_rd = 1'b0;
    endtask

    task automatic bus_write(input int addr, input logic [31:0] data);
        @(negedge clk);
        bus_addr  = ADDR_W'(addr);
        bus_wdata = data;
        bus_wr    = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic eoi();
        bus_write(3, 32'h0);
    endtask

    task automatic cfg_src(input int idx, input int prio);
        bus_write(64 + 2*idx, 32'(prio));
        bus_write(65 + 2*idx, VBASE | 32'(idx));
    endtask

    task automatic set_src(input int idx, input logic val);
        @(negedge clk);
        irq_src[idx] = val;
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
    endtask

    task automatic check_irq(input logic exp, input string tag);
        @(negedge clk);
        #2 check(32'(irq_n), 32'(exp), tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        check_irq(1'b1, "R1 irq idle after reset");
        bus_read(0, 32'h0, "R1 enable mask reset");
        bus_read(5, 32'h0, "R1 pending reset");
        bus_read(6, 32'h8000_0000, "R1 nothing in service");
        bus_read(2, 32'h0, "R10 default vector after reset");

        bus_write(4, DFLT);
        cfg_src(3, 2);
        cfg_src(5, 2);
        cfg_src(7, 5);
        cfg_src(9, 6);
        cfg_src(10, 6);
        cfg_src(12, 7);
        bus_write(1, 32'h0000_0628);
        bus_write(0, 32'h0000_06A8);

        // R4: disabled source 12 at top priority is ignored
        set_src(12, 1'b1);
        settle();
        check_irq(1'b1, "R4 disabled source ignored");

        // R4/R5: equal priorities, lowest number wins
        @(negedge clk);
        irq_src[3] = 1'b1;
        irq_src[5] = 1'b1;
        settle();
        check_irq(1'b0, "R5 request with empty stack");
        bus_read(2, VBASE | 32'd3, "R4 tie goes to lowest number");
        set_src(5, 1'b0);
        check_irq(1'b1, "R8 equal priority does not preempt");
        settle();
        bus_read(5, 32'h0000_1020, "R2 R7 held edge not re-pended");
        bus_read(6, 32'd3, "R6 current source number");

        // R8: level source above current level preempts
        set_src(7, 1'b1);
        settle();
        check_irq(1'b0, "R8 higher priority preempts");
        bus_read(2, VBASE | 32'd7, "R6 vector of level source");
        check_irq(1'b1, "R6 request drops after acknowledge");
        bus_read(5, 32'h0000_10A0, "R3 level stays pending after ack");

        @(negedge clk);
        irq_src[9]  = 1'b1;
        irq_src[10] = 1'b1;
        settle();
        check_irq(1'b0, "R8 priority 6 above level 5");
        bus_read(2, VBASE | 32'd9, "R4 tie at priority 6");
        @(negedge clk);
        irq_src[9]  = 1'b0;
        irq_src[10] = 1'b0;
        check_irq(1'b1, "R8 source 10 equal to level");

        // R10: default read pushes nothing
        bus_read(2, DFLT, "R10 default vector when none above");
        check_irq(1'b1, "R10 request still high");
        eoi();
        check_irq(1'b0, "R9 pop to level 5 exposes priority 6");
        bus_read(2, VBASE | 32'd10, "R9 source 10 served");
        eoi();
        check_irq(1'b1, "R9 level 5 restored, source 7 equal");
        eoi();
        check_irq(1'b0, "R9 source at finished level re-raises");
        set_src(7, 1'b0);
        settle();
        check_irq(1'b1, "R3 level drop clears pending");
        eoi();
        check_irq(1'b0, "R9 empty stack exposes source 5");
        bus_read(2, VBASE | 32'd5, "R6 source 5 served");
        eoi();
        check_irq(1'b1, "R7 nothing left pending");

        // R11: extra end-of-interrupt on an empty stack
        eoi();
        check_irq(1'b1, "R11 empty pop no effect");
        bus_read(6, 32'h8000_0000, "R11 still nothing in service");
        set_src(3, 1'b0);
        settle();
        set_src(3, 1'b1);
        settle();
        check_irq(1'b0, "R11 fresh edge seen after empty pop");
        bus_read(2, VBASE | 32'd3, "R2 new edge served");
        eoi();
        set_src(3, 1'b0);
        check_irq(1'b1, "R7 edge cleared");

        // R12: eight nested levels
        for (int k = 0; k < 8; k++) cfg_src(20 + k, k);
        bus_write(1, 32'h0FF0_0628);
        bus_write(0, 32'h0FF0_06A8);
        for (int k = 0; k < 8; k++) begin
            set_src(20 + k, 1'b1);
            settle();
            set_src(20 + k, 1'b0);
            check_irq(1'b0, $sformatf("R12 level %0d requested", k));
            bus_read(2, VBASE | 32'(20 + k), $sformatf("R12 level %0d vector", k));
        end
        check_irq(1'b1, "R12 full stack quiet");
        set_src(27, 1'b1);
        settle();
        set_src(27, 1'b0);
        check_irq(1'b1, "R8 top priority pending at top level");
        for (int k = 7; k > 0; k--) begin
            eoi();
            bus_read(6, 32'(20 + k - 1), $sformatf("R12 unwind to source %0d", 20 + k - 1));
        end
        eoi();
        check_irq(1'b0, "R12 stack empty, source 27 requests");
        bus_read(2, VBASE | 32'd27, "R12 source 27 served");
        eoi();
        check_irq(1'b1, "R12 all done");

        repeat (4) @(posedge clk);
        finish_run();
    end
endmodule